// File: doc/BRIEF.md
# Debounced push-button LED toggler

This block takes the raw level from a mechanical push-button and drives one LED bit. The LED changes state exactly once for each press and release. A bouncing contact produces a burst of short pulses on every press and on every release. Without filtering, each pulse would count as a press: an even number of pulses would happen to leave the LED in the right state, and an odd number would leave it wrong. To prevent this, the raw input first passes through a synchronizer. It then passes through a settle filter, which adopts a new level only after the input has held that level for an unbroken interval. The interval applies to high and low levels alike.

A registered edge detector watches the accepted level for one chosen transition and flips the LED register when it sees it. By default the chosen transition is the fall from 1 to 0, which happens on release. The settle interval is set in microseconds and the clock frequency in hertz. The defaults are 25 MHz and 10 ms, which give 250,000 cycles held in an 18-bit counter.

Top module: `btn_led_toggle`

## Requirements
- R1: While reset is high and after it is released, the LED output is 0, and the internal accepted button level is 0.
- R2: A new level is accepted once the synchronized input has differed from the accepted level on LIMIT consecutive clock edges (LIMIT = CLK_FREQ_HZ/1,000,000 × SETTLE_US). A raw press lasting exactly LIMIT cycles is therefore accepted.
- R3: A raw pulse shorter than LIMIT cycles, whether it is high from an accepted 0 or low from an accepted 1, never changes the accepted level. As a result, the LED does not change.
- R4: When the input returns to the accepted level, the settle counter clears. Two pulses of LIMIT−1 cycles each, separated by one cycle at the accepted level, are not accepted.
- R5: With the default edge selection, the LED toggles only when the accepted level falls from 1 to 0, which is on release. Holding the button pressed does not change the LED. After the first release the LED is 1, and after the second it is 0.
- R6: A press and a release, each surrounded by bursts of bounce pulses shorter than LIMIT cycles, produce exactly one LED toggle.
- R7: After the raw input goes low and stays low, the LED changes on the (LIMIT+3)-th rising clock edge. That count is made of two synchronizer stages, LIMIT filter edges and one toggle register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| btn_raw | input | 1 | Raw button level, 1 = pressed |
| led | output | 1 | Registered LED drive |

## Verification
Several properties are checked on every cycle inside the modules. The settle counter stays below LIMIT. The accepted level changes only on a cycle where the counter stood at LIMIT−1 and the input disagreed with the level. The counter is zero after any cycle where the input matched the level. The LED changes only one cycle after a falling accepted level. Other behaviours can be shown only by the bench's scenarios: exactly one toggle per bounced press, glitches being ignored, the exact boundary at LIMIT and LIMIT−1 cycles, and the LIMIT+3 cycle latency. The bench shows these by driving the raw input and watching the LED port.

// File: rtl/btn_pkg.sv
package btn_pkg;

   typedef enum logic [1:0] {
      EDGE_FALL = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_ANY  = 2'd2
   } edge_sel_e;

   function automatic int settle_cycles(input longint clk_hz, input longint settle_us);
      return int'((clk_hz / 64'd1_000_000) * settle_us);
   endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_async,
   output logic q_sync
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("btn_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/btn_settle.sv
module btn_settle #(
   parameter int LIMIT = 250_000
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic level
);

   localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   generate
      if (LIMIT < 2) begin : g_bad
         $error("btn_settle: LIMIT must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         level <= 1'b0;
         cnt   <= '0;
      end else if (din != level) begin
         if (cnt < LAST) begin
            cnt <= cnt + 1'b1;
         end else begin
            level <= din;
            cnt   <= '0;
         end
      end else begin
         cnt <= '0;
      end
   end

   // R2: counter never reaches LIMIT
   always_comb begin
      if (!rst) a_r2_cnt_bound: assert (cnt <= LAST);
   end

   // R2 / R3: level moves only after a full run of disagreeing samples
   a_r3_level_needs_full_count: assert property (@(posedge clk) disable iff (rst)
      !$stable(level) |-> ($past(cnt) == LAST && $past(din) != $past(level)));

   // R4: agreement with the accepted level clears the counter
   a_r4_cnt_clears: assert property (@(posedge clk) disable iff (rst)
      (din == level) |=> (cnt == '0));

endmodule

// File: rtl/btn_toggle.sv
module btn_toggle #(
   parameter btn_pkg::edge_sel_e EDGE = btn_pkg::EDGE_FALL
) (
   input  logic clk,
   input  logic rst,
   input  logic lvl,
   output logic led
);

   logic lvl_q;
   logic hit;

   generate
      if (EDGE == btn_pkg::EDGE_FALL) begin : g_fall
         assign hit = lvl_q & ~lvl;
         // R5: LED flips only one cycle after the level fell
         a_r5_flip_on_fall: assert property (@(posedge clk) disable iff (rst)
            !$stable(led) |-> (!$past(lvl) && $past(lvl, 2)));
      end else if (EDGE == btn_pkg::EDGE_RISE) begin : g_rise
         assign hit = ~lvl_q & lvl;
         a_r5_flip_on_rise: assert property (@(posedge clk) disable iff (rst)
            !$stable(led) |-> ($past(lvl) && !$past(lvl, 2)));
      end else begin : g_any
         assign hit = lvl_q ^ lvl;
         a_r5_flip_on_any: assert property (@(posedge clk) disable iff (rst)
            !$stable(led) |-> ($past(lvl) != $past(lvl, 2)));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         lvl_q <= 1'b0;
         led   <= 1'b0;
      end else begin
         lvl_q <= lvl;
         if (hit) led <= ~led;
      end
   end

   // R1: LED is off while reset is held
   a_r1_reset_led: assert property (@(posedge clk) rst |=> !led);

endmodule

// File: rtl/btn_led_toggle.sv
module btn_led_toggle #(
   parameter longint             CLK_FREQ_HZ = 25_000_000,
   parameter longint             SETTLE_US   = 10_000,
   parameter int                 SYNC_STAGES = 2,
   parameter btn_pkg::edge_sel_e TOGGLE_EDGE = btn_pkg::EDGE_FALL
) (
   input  logic clk,
   input  logic rst,
   input  logic btn_raw,
   output logic led
);

   localparam int LIMIT = btn_pkg::settle_cycles(CLK_FREQ_HZ, SETTLE_US);

   generate
      if (CLK_FREQ_HZ < 1_000_000) begin : g_bad_clk
         $error("btn_led_toggle: clock below 1 MHz is not supported");
      end
   endgenerate

   logic btn_s;
   logic btn_lvl;

   btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d_async(btn_raw), .q_sync(btn_s)
   );

   btn_settle #(.LIMIT(LIMIT)) u_settle (
      .clk(clk), .rst(rst), .din(btn_s), .level(btn_lvl)
   );

   btn_toggle #(.EDGE(TOGGLE_EDGE)) u_toggle (
      .clk(clk), .rst(rst), .lvl(btn_lvl), .led(led)
   );

endmodule

// File: tb/tb_btn_led_toggle.sv
module tb_btn_led_toggle;

   localparam int LIMIT = 50;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic btn_raw = 1'b0;
   logic led;

   int checks = 0;
   int errors = 0;
   bit expected_q[$];
   logic led_seen = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   btn_led_toggle #(
      .CLK_FREQ_HZ(1_000_000),
      .SETTLE_US(LIMIT),
      .SYNC_STAGES(2),
      .TOGGLE_EDGE(btn_pkg::EDGE_FALL)
   ) dut (
      .clk(clk), .rst(rst), .btn_raw(btn_raw), .led(led)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic queue_empty(input string req);
      checks++;
      if (expected_q.size() != 0) begin
         errors++;
         $display("FAIL %s: actual %0d pending toggles expected 0", req, expected_q.size());
         expected_q.delete();
      end
   endtask

   // monitor: each LED change must match the next expected value
   always @(negedge clk) begin
      if (!rst && led !== led_seen) begin
         checks++;
         if (expected_q.size() == 0) begin
            errors++;
            $display("FAIL R3/R6: actual unexpected toggle to %0b expected none", led);
         end else begin
            automatic bit e = expected_q.pop_front();
            if (led !== e) begin
               errors++;
               $display("FAIL R5/R6: actual %0b expected %0b", led, e);
            end
         end
         led_seen = led;
      end
   end

   task automatic bounce(input logic base);
      int n = $urandom_range(6, 1);
      for (int i = 0; i < n; i++) begin
         btn_raw = ~base;
         cyc($urandom_range(LIMIT - 2, 1));
         btn_raw = base;
         cyc($urandom_range(LIMIT - 2, 1));
      end
   endtask

   logic model_led = 1'b0;

   initial begin
      cyc(5);
      chk("R1", led, 1'b0);
      rst = 1'b0;
      cyc(3);
      chk("R1", led, 1'b0);

      // R3: single short high glitch
      btn_raw = 1'b1; cyc(LIMIT - 1); btn_raw = 1'b0; cyc(3 * LIMIT);
      chk("R3", led, model_led);
      queue_empty("R3");

      // R4: two short pulses with one-cycle gap
      btn_raw = 1'b1; cyc(LIMIT - 1); btn_raw = 1'b0; cyc(1);
      btn_raw = 1'b1; cyc(LIMIT - 1); btn_raw = 1'b0; cyc(3 * LIMIT);
      chk("R4", led, model_led);
      queue_empty("R4");

      // R2: press of exactly LIMIT cycles accepted; toggle on release
      model_led = ~model_led; expected_q.push_back(model_led);
      btn_raw = 1'b1; cyc(LIMIT); btn_raw = 1'b0; cyc(3 * LIMIT);
      chk("R2", led, model_led);
      queue_empty("R2");

      // R5 + R7: clean long press, no toggle while held, exact latency
      btn_raw = 1'b1; cyc(4 * LIMIT);
      chk("R5", led, model_led);
      // R3: short low glitch while pressed is ignored
      btn_raw = 1'b0; cyc(LIMIT - 1); btn_raw = 1'b1; cyc(2 * LIMIT);
      chk("R3", led, model_led);
      queue_empty("R3");
      model_led = ~model_led; expected_q.push_back(model_led);
      btn_raw = 1'b0;
      cyc(LIMIT + 2);
      chk("R7", led, ~model_led);
      cyc(1);
      chk("R7", led, model_led);
      cyc(2 * LIMIT);
      chk("R5", led, 1'b0);
      queue_empty("R7");

      // R6: bounced presses
      for (int p = 0; p < 8; p++) begin
         bounce(1'b0);
         btn_raw = 1'b1; cyc(LIMIT + 10);
         chk("R6", led, model_led);
         model_led = ~model_led; expected_q.push_back(model_led);
         bounce(1'b1);
         btn_raw = 1'b0; cyc(LIMIT + 10);
         chk("R6", led, model_led);
         queue_empty("R6");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150_000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule